// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block sits between a simple register interface and one analog-to-digital converter that is shared by eight analog inputs. Software programs a conversion mode, a channel or a channel group and a clock divider, then sets a start flag. The sequencer selects the channel to convert and pulses the converter's start line. It waits for the converter's done strobe and stores each 10-bit result in that channel's own 16-bit result register. In the finite modes it clears the start flag itself when the work is complete.

Five modes are offered: convert one channel once, convert one channel continuously, sweep a group once, and two continuous sweep modes that differ in the groups they offer. The block also derives a conversion-clock enable from the input clock through a selectable divider. It reports the number of conversion-clock cycles that a conversion takes, which depends on the resolution and on whether sample-and-hold is used. In the single-shot mode it can raise a sticky interrupt request.

Top module: `adc_scan_seq`

## Requirements
- R1: A one-cycle pulse on start_set while idle sets busy. A pulse on start_clr at any point clears busy at the next edge and stops the sequence. A conversion that is in flight at that point writes no result.
- R2: mode 0 (and the alias codes 5, 6, 7) converts channel chan_sel once, stores the result and then clears busy.
- R3: At the end of a mode 0 conversion irq is set if irq_level is nonzero. It stays set until an irq_clr pulse. It is never set by modes 1 to 4.
- R4: mode 1 converts channel chan_sel repeatedly and keeps busy set until software stops it.
- R5: mode 2 converts channels 0 up to 2*group_sel+1 (groups 0-1, 0-3, 0-5, 0-7) once in ascending order, then clears busy.
- R6: mode 3 sweeps the same groups as mode 2 without end, wrapping from the last channel back to channel 0. mode 4 sweeps channels 0 up to group_sel (groups 0, 0-1, 0-2, 0-3) without end. In mode 4, registers of channels outside the group keep their values.
- R7: Each channel has a 16-bit result register that reads as zero after reset. It holds the converter's 10-bit data in bits 9:0 with bits 15:10 zero and is read combinationally through rd_chan.
- R8: conv_tick is a one-cycle pulse every N clock cycles, where div_sel 0..5 selects N = 1, 2, 3, 4, 6, 12 and codes 6 and 7 select 12.
- R9: conv_len is 28 (res10=0) or 33 (res10=1) with use_sh=1, and 49 or 59 with use_sh=0.
- R10: mode, chan_sel, group_sel and irq_level are captured at start. A start_set pulse or a change of these inputs while busy has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_set | input | 1 | Software writes 1 to the start flag |
| start_clr | input | 1 | Software writes 0 to the start flag |
| irq_clr | input | 1 | Software clears the interrupt request |
| mode | input | 3 | Conversion mode code |
| chan_sel | input | 3 | Channel for modes 0 and 1 |
| group_sel | input | 2 | Sweep group select |
| div_sel | input | 3 | Conversion clock divider select |
| res10 | input | 1 | 1 = 10-bit, 0 = 8-bit conversion |
| use_sh | input | 1 | Sample-and-hold in use |
| irq_level | input | 3 | Interrupt level, 0 disables the request |
| rd_chan | input | 3 | Result register read select |
| conv_done | input | 1 | Converter finished strobe |
| conv_data | input | 10 | Converter result |
| busy | output | 1 | Start flag |
| irq | output | 1 | Sticky interrupt request |
| rd_data | output | 16 | Selected result register |
| conv_start | output | 1 | One-cycle converter start pulse |
| conv_chan | output | 3 | Channel being converted |
| conv_tick | output | 1 | Conversion clock enable |
| conv_len | output | 6 | Conversion length in conversion-clock cycles |

## Verification
On every cycle the assertions check several things. The flag drops after a software clear and after the last conversion of a finite mode. Continuous modes reissue a start after each done. Sweeps wrap to their first channel, the interrupt request stays sticky, and the configuration is frozen while busy. They also check that a divided tick is never followed by a second tick, and that a written result reads back. Only the bench scenarios show the channel order of each mode and group, the exact divider periods and conversion lengths, and whether untouched registers keep their contents. They also show that an aborted conversion leaves its register alone.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int NCH   = 8;
    localparam int CH_W  = $clog2(NCH);
    localparam int RES_W = 10;
    localparam int REG_W = 16;

    localparam logic [2:0] MD_ONCE    = 3'd0;
    localparam logic [2:0] MD_REPEAT  = 3'd1;
    localparam logic [2:0] MD_SWEEP   = 3'd2;
    localparam logic [2:0] MD_RSWEEPA = 3'd3;
    localparam logic [2:0] MD_RSWEEPB = 3'd4;

    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_state_t;
endpackage

// File: rtl/adcseq_clkdiv.sv
module adcseq_clkdiv #(
    parameter int CNT_W   = 4,
    parameter int LEN_W   = 6,
    parameter int LEN_SH8 = 28,
    parameter int LEN_SH10 = 33,
    parameter int LEN_NS8 = 49,
    parameter int LEN_NS10 = 59
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       div_sel,
    input  logic             res10,
    input  logic             use_sh,
    output logic             tick,
    output logic [LEN_W-1:0] conv_len
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } div_reg_t;

    div_reg_t r_d, r_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        case (div_sel)
            3'd0:    lim = CNT_W'(1);
            3'd1:    lim = CNT_W'(2);
            3'd2:    lim = CNT_W'(3);
            3'd3:    lim = CNT_W'(4);
            3'd4:    lim = CNT_W'(6);
            default: lim = CNT_W'(12);
        endcase
        r_d = r_q;
        if (r_q.cnt >= lim - CNT_W'(1)) begin
            r_d.cnt  = '0;
            r_d.tick = 1'b1;
        end else begin
            r_d.cnt  = r_q.cnt + CNT_W'(1);
            r_d.tick = 1'b0;
        end
        case ({use_sh, res10})
            2'b10:   conv_len = LEN_W'(LEN_SH8);
            2'b11:   conv_len = LEN_W'(LEN_SH10);
            2'b00:   conv_len = LEN_W'(LEN_NS8);
            default: conv_len = LEN_W'(LEN_NS10);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tick = r_q.tick;

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && lim > CNT_W'(1)) |=> (!tick || !$stable(div_sel))); // R8
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
    import adc_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_set,
    input  logic            start_clr,
    input  logic            irq_clr,
    input  logic [2:0]      mode,
    input  logic [CH_W-1:0] chan_sel,
    input  logic [1:0]      group_sel,
    input  logic [2:0]      irq_level,
    input  logic            conv_done,
    output logic            flag,
    output logic            conv_start,
    output logic [CH_W-1:0] cur_chan,
    output logic            wr_en,
    output logic            irq
);
    typedef struct packed {
        seq_state_t      state;
        logic            flag;
        logic [2:0]      mode;
        logic [CH_W-1:0] first;
        logic [CH_W-1:0] last;
        logic [CH_W-1:0] cur;
        logic            irq_en;
        logic            irq;
    } ctrl_reg_t;

    ctrl_reg_t r_d, r_q;
    logic finite, once_cls, at_last;

    always_comb begin
        once_cls = !(r_q.mode inside {MD_REPEAT, MD_SWEEP, MD_RSWEEPA, MD_RSWEEPB});
        finite   = once_cls || (r_q.mode == MD_SWEEP);
        at_last  = (r_q.cur == r_q.last);
        wr_en    = (r_q.state == S_WAIT) && conv_done && !start_clr;
        r_d      = r_q;
        if (irq_clr) r_d.irq = 1'b0;

        case (r_q.state)
            S_IDLE: begin
                if (start_set && !start_clr) begin
                    r_d.state  = S_ISSUE;
                    r_d.flag   = 1'b1;
                    r_d.mode   = mode;
                    r_d.irq_en = (irq_level != 3'd0);
                    case (mode)
                        MD_SWEEP, MD_RSWEEPA: begin
                            r_d.first = '0;
                            r_d.last  = {group_sel, 1'b1};
                        end
                        MD_RSWEEPB: begin
                            r_d.first = '0;
                            r_d.last  = {1'b0, group_sel};
                        end
                        default: begin
                            r_d.first = chan_sel;
                            r_d.last  = chan_sel;
                        end
                    endcase
                    r_d.cur = r_d.first;
                end
            end
            S_ISSUE: begin
                r_d.state = start_clr ? S_IDLE : S_WAIT;
                if (start_clr) r_d.flag = 1'b0;
            end
            default: begin
                if (start_clr) begin
                    r_d.state = S_IDLE;
                    r_d.flag  = 1'b0;
                end else if (conv_done) begin
                    if (finite && at_last) begin
                        r_d.state = S_IDLE;
                        r_d.flag  = 1'b0;
                        if (once_cls && r_q.irq_en) r_d.irq = 1'b1;
                    end else begin
                        r_d.state = S_ISSUE;
                        r_d.cur   = at_last ? r_q.first : r_q.cur + CH_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: S_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign flag       = r_q.flag;
    assign conv_start = (r_q.state == S_ISSUE);
    assign cur_chan   = r_q.cur;
    assign irq        = r_q.irq;

    AST_SW_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (start_clr && r_q.flag) |=> !r_q.flag); // R1
    AST_FINITE_END: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && finite && at_last) |=> !r_q.flag); // R2
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.irq && !irq_clr) |=> r_q.irq); // R3
    AST_REPEAT_GOES_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !finite) |=> (r_q.flag && conv_start)); // R4
    AST_SWEEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !finite && at_last) |=> (r_q.cur == r_q.first)); // R6
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.flag && !start_clr && !wr_en) |=> ($stable(r_q.mode) && $stable(r_q.last))); // R10
endmodule

// File: rtl/adcseq_results.sv
module adcseq_results
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_chan,
    input  logic [RES_W-1:0] wr_data,
    input  logic [CH_W-1:0]  rd_chan,
    output logic [REG_W-1:0] rd_data
);
    logic [REG_W-1:0] regs_q [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_reg
        logic [REG_W-1:0] reg_d;
        always_comb begin
            reg_d = regs_q[g];
            if (wr_en && wr_chan == CH_W'(g)) reg_d = {{(REG_W-RES_W){1'b0}}, wr_data};
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs_q[g] <= '0;
            else        regs_q[g] <= reg_d;
        end
    end

    assign rd_data = regs_q[rd_chan];

    AST_READ_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_chan == rd_chan && $stable(rd_chan)) |=>
        (rd_data[RES_W-1:0] == $past(wr_data) || !$stable(rd_chan))); // R7
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_set,
    input  logic              start_clr,
    input  logic              irq_clr,
    input  logic [2:0]        mode,
    input  logic [2:0]        chan_sel,
    input  logic [1:0]        group_sel,
    input  logic [2:0]        div_sel,
    input  logic              res10,
    input  logic              use_sh,
    input  logic [2:0]        irq_level,
    input  logic [2:0]        rd_chan,
    input  logic              conv_done,
    input  logic [9:0]        conv_data,
    output logic              busy,
    output logic              irq,
    output logic [15:0]       rd_data,
    output logic              conv_start,
    output logic [2:0]        conv_chan,
    output logic              conv_tick,
    output logic [5:0]        conv_len
);
    logic wr_en;

    adcseq_clkdiv u_div (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .res10(res10),
        .use_sh(use_sh), .tick(conv_tick), .conv_len(conv_len)
    );

    adcseq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_set(start_set), .start_clr(start_clr),
        .irq_clr(irq_clr), .mode(mode), .chan_sel(chan_sel), .group_sel(group_sel),
        .irq_level(irq_level), .conv_done(conv_done), .flag(busy),
        .conv_start(conv_start), .cur_chan(conv_chan), .wr_en(wr_en), .irq(irq)
    );

    adcseq_results u_res (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(conv_chan),
        .wr_data(conv_data), .rd_chan(rd_chan), .rd_data(rd_data)
    );
endmodule

// File: tb/sim_adc_scan_seq.sv
module sim_adc_scan_seq;
    logic clk = 0, rst_n = 0;
    logic start_set = 0, start_clr = 0, irq_clr = 0;
    logic [2:0] mode = 0, chan_sel = 0, div_sel = 0, irq_level = 0, rd_chan = 0;
    logic [1:0] group_sel = 0;
    logic res10 = 0, use_sh = 1;
    logic conv_done, busy, irq, conv_start, conv_tick;
    logic [9:0] conv_data;
    logic [15:0] rd_data;
    logic [2:0] conv_chan;
    logic [5:0] conv_len;

    always #2 clk = ~clk;

    adc_scan_seq u0 (.*);

    int n_chk = 0, n_fail = 0, log_n = 0, kcnt = 0;
    logic [2:0] log_ch [32];
    logic [15:0] model_last [8];
    bit finished = 0;

    typedef struct packed {
        logic [2:0]  md;
        logic [2:0]  ch;
        logic [1:0]  grp;
        logic [3:0]  n;
        logic [23:0] ord;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{3'd0, 3'd5, 2'd0, 4'd1, 24'o5},        // R2
        '{3'd7, 3'd3, 2'd0, 4'd1, 24'o3},        // R2 alias code
        '{3'd2, 3'd0, 2'd0, 4'd2, 24'o10},       // R5
        '{3'd2, 3'd6, 2'd1, 4'd4, 24'o3210},     // R5
        '{3'd2, 3'd0, 2'd2, 4'd6, 24'o543210},   // R5
        '{3'd2, 3'd1, 2'd3, 4'd8, 24'o76543210}  // R5
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // converter model
    initial begin
        conv_done = 0; conv_data = 0;
        for (int i = 0; i < 8; i++) model_last[i] = 0;
        forever begin
            if (conv_start) begin
                automatic logic [2:0] ch = conv_chan;
                automatic int cnt = 0;
                if (log_n < 32) log_ch[log_n] = ch;
                log_n++;
                while (cnt < int'(conv_len)) begin
                    @(negedge clk);
                    if (conv_tick) cnt++;
                end
                kcnt++;
                conv_done = 1;
                conv_data = {ch, 7'(kcnt)};
                if (busy) model_last[ch] = {6'b0, ch, 7'(kcnt)};
                @(negedge clk);
                conv_done = 0;
            end else @(negedge clk);
        end
    end

    task automatic pulse_start();
        start_set = 1; @(negedge clk); start_set = 0;
    endtask
    task automatic pulse_stop();
        start_clr = 1; @(negedge clk); start_clr = 0;
    endtask
    task automatic wait_idle();
        int t = 0;
        while (busy && t < 5000) begin @(negedge clk); t++; end
    endtask
    task automatic wait_log(input int n);
        int t = 0;
        while (log_n < n && t < 5000) begin @(negedge clk); t++; end
    endtask
    task automatic chk_ord(input int n, input logic [23:0] ord, input string tag);
        for (int i = 0; i < n; i++)
            chk(log_ch[i] == ord[3*i +: 3], tag, int'(log_ch[i]), int'(ord[3*i +: 3]));
    endtask
    task automatic chk_reg(input logic [2:0] c, input string tag);
        rd_chan = c; #0;
        chk(rd_data == model_last[c], tag, int'(rd_data), int'(model_last[c]));
    endtask
    task automatic tick_period(input logic [2:0] sel, input int exp);
        int p = 0;
        div_sel = sel;
        repeat (30) @(negedge clk);
        while (!conv_tick) @(negedge clk);
        @(negedge clk); p = 1;
        while (!conv_tick && p < 40) begin @(negedge clk); p++; end
        chk(p == exp, "R8 divider period", p, exp);
    endtask

    initial begin
        #(4 * 150000);
        chk(0, "watchdog", 0, 1);
        if (!finished) begin
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0, "R1 reset busy", busy, 0);
        chk(irq == 0, "R3 reset irq", irq, 0);
        chk(conv_start == 0, "R1 reset start", conv_start, 0);
        rd_chan = 0; #0; chk(rd_data == 0, "R7 reset reg0", rd_data, 0);
        rd_chan = 7; #0; chk(rd_data == 0, "R7 reset reg7", rd_data, 0);
        rst_n = 1;
        @(negedge clk);

        // table of finite-mode scenarios
        foreach (VEC[v]) begin
            log_n = 0;
            mode = VEC[v].md; chan_sel = VEC[v].ch; group_sel = VEC[v].grp;
            pulse_start();
            chk(busy == 1, "R1 busy after start", busy, 1);
            wait_idle();
            chk(busy == 0, "R2/R5 flag self-clear", busy, 0);
            chk(log_n == int'(VEC[v].n), "R5 conversion count", log_n, int'(VEC[v].n));
            chk_ord(int'(VEC[v].n), VEC[v].ord, "R5 channel order");
            for (int i = 0; i < int'(VEC[v].n); i++) chk_reg(VEC[v].ord[3*i +: 3], "R7 result value");
            rd_chan = VEC[v].ord[2:0]; #0;
            chk(rd_data[15:10] == 0, "R7 upper bits zero", int'(rd_data[15:10]), 0);
            chk(irq == 0, "R3 level zero no irq", irq, 0);
            repeat (5) @(negedge clk);
        end

        // R3: one-shot with level, sticky, clear
        log_n = 0; mode = 0; chan_sel = 2; irq_level = 3;
        pulse_start(); wait_idle();
        chk(irq == 1, "R3 irq set", irq, 1);
        repeat (10) @(negedge clk);
        chk(irq == 1, "R3 irq sticky", irq, 1);
        irq_clr = 1; @(negedge clk); irq_clr = 0;
        chk(irq == 0, "R3 irq cleared", irq, 0);

        // R4: repeat single channel, then R1 abort
        log_n = 0; mode = 1; chan_sel = 6;
        pulse_start(); wait_log(3);
        chk(busy == 1, "R4 still busy", busy, 1);
        chk(irq == 0, "R3 no irq in repeat", irq, 0);
        chk_ord(3, 24'o666, "R4 same channel");
        pulse_stop();
        chk(busy == 0, "R1 software stop", busy, 0);
        begin
            automatic int n0 = log_n;
            repeat (100) @(negedge clk);
            chk(log_n == n0, "R1 no start after stop", log_n, n0);
        end
        chk_reg(6, "R1 aborted result not written");

        // R6: repeat sweep mode 0, group 1 (0..3)
        log_n = 0; mode = 3; group_sel = 1;
        pulse_start(); wait_log(6);
        chk_ord(6, 24'o103210, "R6 sweep0 wrap order");
        pulse_stop(); repeat (100) @(negedge clk);

        // R6/R10: repeat sweep mode 1, group 2 (0..2), start/config ignored while busy
        log_n = 0; mode = 4; group_sel = 2;
        pulse_start();
        mode = 0; chan_sel = 7; group_sel = 3; irq_level = 1;
        repeat (5) @(negedge clk);
        pulse_start();
        wait_log(6);
        chk_ord(6, 24'o210210, "R6 sweep1 order / R10 ignored start");
        chk(busy == 1, "R10 still running", busy, 1);
        pulse_stop(); repeat (100) @(negedge clk);
        chk(irq == 0, "R3 no irq in sweep1", irq, 0);
        chk_reg(5, "R6 outside group kept");
        chk_reg(7, "R6 outside group kept");
        chk_reg(3, "R6 outside group kept");

        // R8 divider, R9 lengths
        tick_period(3'd4, 6);
        tick_period(3'd2, 3);
        tick_period(3'd5, 12);
        tick_period(3'd7, 12);
        tick_period(3'd0, 1);
        use_sh = 1; res10 = 0; #1 chk(conv_len == 28, "R9 len", conv_len, 28);
        use_sh = 1; res10 = 1; #1 chk(conv_len == 33, "R9 len", conv_len, 33);
        use_sh = 0; res10 = 0; #1 chk(conv_len == 49, "R9 len", conv_len, 49);
        use_sh = 0; res10 = 1; #1 chk(conv_len == 59, "R9 len", conv_len, 59);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule